// File: doc/BRIEF.md
# Frame-Gated Serial Transmit Channel

This block is one transmit lane of a synchronous serial port. A host loads words into a parallel holding register. The channel moves each word into a shift register and sends it on a single serial data pin, most significant bit first. Bit timing comes in as a one-cycle strobe, and frame timing comes in as a frame pulse. Both are produced elsewhere. This block only consumes them.

A channel-enable bit gates the path from the holding register to the shifter. When the bit is set, the channel waits for the next frame pulse before it starts. When the bit is cleared, the word already on the wire is finished before the pin is released to high impedance. While the bit is clear, host writes still mark the holding register as full, but the data is dropped and never sent.

At every frame pulse the active channel reloads the shifter and raises the empty flag. If the host wrote nothing since the previous reload, the old word goes out again and a sticky underrun flag is set.

The control FSM has four states:
- `ST_OFF`: disabled, pin released.
- `ST_ARMED`: enabled, waiting for the first frame pulse, pin released.
- `ST_SHIFT`: word on the wire, pin driven.
- `ST_GAP`: enabled, word done, waiting for the next frame pulse, pin released.

The transitions are:
- `OFF→ARMED`: the enable bit is set.
- `ARMED→SHIFT`: a frame pulse arrives on a bit strobe (this is a load).
- `ARMED→OFF`: the enable bit is cleared.
- `SHIFT→SHIFT`: either a bit shift, or a back-to-back reload at word end with a frame pulse and the enable set.
- `SHIFT→GAP`: word end with the enable set and no frame pulse.
- `SHIFT→OFF`: word end with the enable clear.
- `GAP→SHIFT`: a frame pulse arrives (this is a load).
- `GAP→OFF`: the enable bit is cleared.

Top module: `ftx_tx_chan`

## Requirements
- R1: After the enable bit is set, `sdo_oe` stays 0 until a bit strobe that coincides with a frame pulse. The first word starts on that strobe.
- R2: Clearing the enable bit (via `en_wr` with `en_val`=0) in the middle of a word does not cut that word short. All W bits are sent before `sdo_oe` falls. No further word follows.
- R3: `sdo_oe` is 1 only while a word is being shifted. In every other state it is 0, which releases the pin to high impedance.
- R4: A host write (`dat_wr`) while the enable bit is 0 sets `tde` to 0 (0 = holding register full). The written data is discarded and never appears on `sdo`.
- R5: Hardware reset (`rst_n`=0) and a one-cycle `soft_rst` pulse both force the enable bit to 0. After `soft_rst`, the word in flight drains and the channel stops.
- R6: On each load, the holding register is copied into the shifter and `tde` returns to 1 (1 = empty). After reset, `tde`=1 and `urun`=0.
- R7: Words are W bits long (default 24) and are sent MSB first. After the loading strobe, `sdo` shows bit W-1. Each later strobe advances one bit toward bit 0.
- R8: A load that finds `tde`=1 resends the previous word and sets `urun`. `urun` holds until `urun_clr`. If a set and a clear occur in the same cycle, the set wins.
- R9: A host write in the same cycle as a load leaves `tde`=0. The load takes the older data, and the new word goes out at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset of the enable bit |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | Value written to the enable bit |
| bit_tick | input | 1 | One-cycle strobe per rising bit-clock edge |
| frame_sync | input | 1 | Frame pulse, qualified by `bit_tick` |
| dat_wr | input | 1 | Host write strobe for the holding register |
| dat_in | input | W | Host write data |
| urun_clr | input | 1 | Clears the sticky underrun flag |
| sdo | output | 1 | Serial data out (0 when not driven) |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| tde | output | 1 | Holding register empty |
| urun | output | 1 | Sticky transmit underrun |

## Verification
A host write and a frame-pulse load can fall in the same clock. The bench provokes this by applying the write strobe in the very step that drives the frame pulse, at a moment when the holding register is empty. The expected result has four parts: the outgoing word is the previous one, `urun` is set, `tde` stays 0 afterwards, and the newly written word is the one sent in the following frame. The scoreboard compares each completed serial word against that expected order.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } ftx_state_t;
endpackage

// File: rtl/ftx_enable.sv
module ftx_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic en_wr,
    input  logic en_val,
    output logic en_q
);
    // software reset takes priority over a same-cycle host write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (soft_rst)
            en_q <= 1'b0;
        else if (en_wr)
            en_q <= en_val;
    end
endmodule

// File: rtl/ftx_fsm.sv
module ftx_fsm
    import ftx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       frame_sync,
    input  logic       en_q,
    input  logic       word_end,
    output ftx_state_t state,
    output logic       load,
    output logic       shift,
    output logic       oe
);
    ftx_state_t nxt;
    logic       sync_hit;

    assign sync_hit = bit_tick && frame_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    always_comb begin
        nxt   = state;
        load  = 1'b0;
        shift = 1'b0;
        oe    = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (en_q)
                    nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en_q) begin
                    nxt = ST_OFF;
                end else if (sync_hit) begin
                    load = 1'b1;
                    nxt  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                oe = 1'b1;
                if (bit_tick) begin
                    if (!word_end)
                        shift = 1'b1;
                    else if (frame_sync && en_q)
                        load = 1'b1;
                    else if (!en_q)
                        nxt = ST_OFF;
                    else
                        nxt = ST_GAP;
                end
            end
            ST_GAP: begin
                if (!en_q) begin
                    nxt = ST_OFF;
                end else if (sync_hit) begin
                    load = 1'b1;
                    nxt  = ST_SHIFT;
                end
            end
            default: nxt = ST_OFF;
        endcase
    end
endmodule

// File: rtl/ftx_holdreg.sv
module ftx_holdreg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_q,
    input  logic         dat_wr,
    input  logic [W-1:0] dat_in,
    input  logic         load,
    input  logic         urun_clr,
    output logic [W-1:0] hold_q,
    output logic         tde,
    output logic         urun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (dat_wr && en_q) begin
            hold_q <= dat_in;
        end
    end

    // a write always marks the register full, also over a same-cycle load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tde <= 1'b1;
        else if (dat_wr)
            tde <= 1'b0;
        else if (load)
            tde <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            urun <= 1'b0;
        else if (load && tde)
            urun <= 1'b1;
        else if (urun_clr)
            urun <= 1'b0;
    end
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] par_in,
    output logic         msb,
    output logic         word_end
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= par_in;
            left_q <= LAST;
        end else if (shift) begin
            sh_q   <= {sh_q[W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign msb      = sh_q[W-1];
    assign word_end = (left_q == '0);
endmodule

// File: rtl/ftx_tx_chan.sv
module ftx_tx_chan
    import ftx_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         en_wr,
    input  logic         en_val,
    input  logic         bit_tick,
    input  logic         frame_sync,
    input  logic         dat_wr,
    input  logic [W-1:0] dat_in,
    input  logic         urun_clr,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         tde,
    output logic         urun
);
    ftx_state_t   state;
    logic         en_q;
    logic         load;
    logic         shift;
    logic         oe;
    logic         word_end;
    logic         msb;
    logic [W-1:0] hold_q;

    ftx_enable u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .en_wr    (en_wr),
        .en_val   (en_val),
        .en_q     (en_q)
    );

    ftx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_sync (frame_sync),
        .en_q       (en_q),
        .word_end   (word_end),
        .state      (state),
        .load       (load),
        .shift      (shift),
        .oe         (oe)
    );

    ftx_holdreg #(.W(W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_q     (en_q),
        .dat_wr   (dat_wr),
        .dat_in   (dat_in),
        .load     (load),
        .urun_clr (urun_clr),
        .hold_q   (hold_q),
        .tde      (tde),
        .urun     (urun)
    );

    ftx_shifter #(.W(W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .par_in   (hold_q),
        .msb      (msb),
        .word_end (word_end)
    );

    assign sdo_oe = oe;
    assign sdo    = oe ? msb : 1'b0;
endmodule

// File: rtl/ftx_tx_checker.sv
module ftx_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic frame_sync,
    input logic dat_wr,
    input logic soft_rst,
    input logic urun_clr,
    input logic sdo_oe,
    input logic tde,
    input logic urun,
    input logic en_q,
    input logic load,
    input logic word_end
);
    a_r1_start_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(bit_tick && frame_sync && en_q));

    a_r2_no_cut_mid_word: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !word_end) |=> sdo_oe);

    a_r3_released_until_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdo_oe && !load) |=> !sdo_oe);

    a_r4_off_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !en_q) |=> !tde);

    a_r5_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !en_q);

    a_r6_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !dat_wr) |=> tde);

    a_r8_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tde) |=> urun);

    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (urun && !urun_clr) |=> urun);

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && load) |=> !tde);
endmodule

bind ftx_tx_chan ftx_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .frame_sync (frame_sync),
    .dat_wr     (dat_wr),
    .soft_rst   (soft_rst),
    .urun_clr   (urun_clr),
    .sdo_oe     (sdo_oe),
    .tde        (tde),
    .urun       (urun),
    .en_q       (en_q),
    .load       (load),
    .word_end   (word_end)
);

// File: tb/ftx_tx_chan_bench.sv
module ftx_tx_chan_bench;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soft_rst = 1'b0;
    logic         en_wr = 1'b0;
    logic         en_val = 1'b0;
    logic         bit_tick = 1'b0;
    logic         frame_sync = 1'b0;
    logic         dat_wr = 1'b0;
    logic [W-1:0] dat_in = '0;
    logic         urun_clr = 1'b0;
    logic         sdo;
    logic         sdo_oe;
    logic         tde;
    logic         urun;

    ftx_tx_chan #(.W(W)) u_ftx_tx_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .en_wr      (en_wr),
        .en_val     (en_val),
        .bit_tick   (bit_tick),
        .frame_sync (frame_sync),
        .dat_wr     (dat_wr),
        .dat_in     (dat_in),
        .urun_clr   (urun_clr),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .tde        (tde),
        .urun       (urun)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] exp_q[$];

    // pending stimulus, applied by step()
    logic         p_wr = 1'b0;
    logic [W-1:0] p_dat = '0;
    logic         p_en_wr = 1'b0;
    logic         p_en_val = 1'b0;
    logic         p_soft = 1'b0;
    logic         p_uclr = 1'b0;
    int           phase = 0;
    int           tickn = 0;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_word(input logic [W-1:0] w);
        exp_q.push_back(w);
    endtask

    task automatic step();
        @(negedge clk);
        phase++;
        bit_tick = phase[0];
        frame_sync = 1'b0;
        if (bit_tick) begin
            tickn++;
            frame_sync = (tickn % W == 0);
        end
        dat_wr = p_wr;  dat_in = p_dat;
        en_wr = p_en_wr; en_val = p_en_val;
        soft_rst = p_soft; urun_clr = p_uclr;
        p_wr = 1'b0; p_en_wr = 1'b0; p_soft = 1'b0; p_uclr = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic to_sync();
        do step(); while (!frame_sync);
    endtask

    task automatic host_write(input logic [W-1:0] d);
        p_wr = 1'b1; p_dat = d; step();
    endtask

    task automatic set_en(input logic v);
        p_en_wr = 1'b1; p_en_val = v; step();
    endtask

    // monitor: collects serial bits and compares whole words (R7)
    logic [W-1:0] acc = '0;
    int           nbits = 0;
    always @(posedge clk) begin
        #1;
        if (rst_n && bit_tick) begin
            if (sdo_oe) begin
                acc = {acc[W-2:0], sdo};
                nbits++;
                if (nbits == W) begin
                    nbits = 0;
                    if (exp_q.size() == 0)
                        chk(1'b0, "R7 unexpected word", acc, '0);
                    else begin
                        logic [W-1:0] e;
                        e = exp_q.pop_front();
                        chk(acc == e, "R7 word content", acc, e);
                    end
                end
            end else if (nbits != 0) begin
                chk(1'b0, "R2 word cut short", W'(nbits), W'(W));
                nbits = 0;
            end
        end
    end

    initial begin
        for (int c = 0; c < 40000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        steps(4);
        rst_n = 1'b1;
        steps(60);
        // R6 reset state, R3 pin released, R5 enable cleared by reset
        chk(sdo_oe == 1'b0, "R3 reset oe", W'(sdo_oe), '0);
        chk(tde == 1'b1, "R6 reset tde", W'(tde), W'(1));
        chk(urun == 1'b0, "R6 reset urun", W'(urun), '0);

        // R4: write while disabled fills flag but data dropped
        host_write(24'hAAAAAA);
        step();
        chk(tde == 1'b0, "R4 tde after disabled write", W'(tde), '0);

        // R1: enable mid-frame, must wait for next sync
        to_sync();
        steps(10);
        set_en(1'b1);
        begin
            bit early = 1'b0;
            step();
            while (!frame_sync) begin
                if (sdo_oe) early = 1'b1;
                step();
            end
            chk(!early, "R1 no output before sync", W'(early), '0);
        end
        push_word(24'h000000);   // R4: dropped write never sent
        step();
        chk(sdo_oe == 1'b1, "R1 active after sync", W'(sdo_oe), W'(1));
        chk(urun == 1'b0, "R8 no underrun on first load", W'(urun), '0);
        chk(tde == 1'b1, "R6 tde after load", W'(tde), W'(1));

        host_write(24'h123456); push_word(24'h123456);
        to_sync(); step();
        host_write(24'h9C3E71); push_word(24'h9C3E71);
        to_sync(); step();
        chk(urun == 1'b0, "R8 urun quiet with data", W'(urun), '0);
        // no write: underrun resends
        push_word(24'h9C3E71);
        to_sync(); step();
        chk(urun == 1'b1, "R8 urun set", W'(urun), W'(1));
        steps(6);
        chk(urun == 1'b1, "R8 urun sticky", W'(urun), W'(1));
        p_uclr = 1'b1; step(); step();
        chk(urun == 1'b0, "R8 urun cleared", W'(urun), '0);

        // R9 collision: write in the sync step, register empty
        do step(); while (!((tickn + 1) % W == 0 && phase[0] == 1'b0));
        p_wr = 1'b1; p_dat = 24'h5A0FF1;
        step();   // this step drives frame_sync and the write together
        chk(frame_sync == 1'b1, "R9 collision aligned", W'(frame_sync), W'(1));
        push_word(24'h9C3E71);
        push_word(24'h5A0FF1);
        step();
        chk(tde == 1'b0, "R9 write wins tde", W'(tde), '0);
        chk(urun == 1'b1, "R9 collision underrun", W'(urun), W'(1));
        p_uclr = 1'b1; step();
        to_sync(); step();
        chk(urun == 1'b0, "R9 new word no underrun", W'(urun), '0);
        chk(tde == 1'b1, "R6 tde after second load", W'(tde), W'(1));

        // R2: disable mid-word
        host_write(24'hC0FFEE); push_word(24'hC0FFEE);
        to_sync(); steps(20);
        set_en(1'b0);
        host_write(24'hDEAD01);   // R4: discarded
        step();
        chk(tde == 1'b0, "R4 tde disabled write", W'(tde), '0);
        to_sync(); to_sync(); steps(4);
        chk(sdo_oe == 1'b0, "R2 released after drain", W'(sdo_oe), '0);
        chk(exp_q.size() == 0, "R2 drained word seen", W'(exp_q.size()), '0);

        // R5: soft reset mid-word
        set_en(1'b1);
        host_write(24'h3C3C3C); push_word(24'h3C3C3C);
        to_sync(); steps(12);
        p_soft = 1'b1; step();
        host_write(24'hBADBAD);   // dropped: enable now 0
        to_sync(); to_sync(); to_sync(); steps(4);
        chk(sdo_oe == 1'b0, "R5 stopped after soft reset", W'(sdo_oe), '0);
        chk(exp_q.size() == 0, "R5 all words seen", W'(exp_q.size()), '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule